// File: doc/BRIEF.md
# Bipolar Six-Zero-Substitution Line Encoder

This block turns a serial binary stream into a three-level bipolar line code, producing one ternary symbol for each accepted bit. Ordinary bits use alternate mark inversion: a one becomes a nonzero level of the polarity opposite to the last nonzero level sent, and a zero becomes the zero level. A transition-poor stream would starve the receiver's clock recovery, so every run of six zeros is replaced by the group zero, V, B, zero, V, B. A V is a mark that deliberately repeats the previous polarity. A B is a mark that alternates as usual. The receiver can detect the repeated polarities without ambiguity and put the six zeros back.

Each input bit is qualified by a bit-rate enable. Bits pass through a six-deep delay line, so a whole zero run is known before its first symbol leaves. The symbol for a bit appears, with a one-cycle valid pulse, after the enable that accepts the sixth bit following it. The polarity tracker is updated by every nonzero symbol, including the V and B marks inside a substitution.

Top module: `b6zs_encoder`

## Requirements
- R1: The symbol code is 2'b01 for the positive level, 2'b10 for the negative level and 2'b00 for zero. The code 2'b11 never appears. After reset the symbol output is 2'b00.
- R2: `sym_vld` pulses for one clock in the cycle after every enable, once six bits are held. The symbol for bit k is presented with the enable that accepts bit k+6. The first six enables after reset produce no valid pulse.
- R3: Outside a substitution, a one is sent as a nonzero level of opposite polarity to the previous nonzero symbol, and a zero is sent as 2'b00.
- R4: After reset the remembered polarity is negative, so the first mark sent is positive.
- R5: Six consecutive zeros are sent as 0, V, B, 0, V, B. A V has the same polarity as the preceding nonzero symbol. A B has the opposite polarity.
- R6: The V and B marks of a substitution update the polarity memory. A mark that follows a substitution is therefore opposite to the final B of that substitution.
- R7: Twelve zeros give two back-to-back substitutions. Seven zeros give one substitution followed by a plain zero. Five zeros are sent as five plain zeros.
- R8: With `bit_en` low, no valid pulse is produced and the encoder state does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; accepts `bit_in` |
| bit_in | input | 1 | Serial data bit |
| sym | output | 2 | Ternary symbol code (01 positive, 10 negative, 00 zero) |
| sym_vld | output | 1 | One-cycle pulse marking a new symbol |

## Verification
Several properties are checked on every clock cycle. The illegal code never appears. A valid pulse only follows an enable. Every ordinary mark and every B flips the polarity memory. Every V repeats the stored polarity, and an ordinary zero gives a zero symbol. Other properties can only be shown by the bench's scenarios, which compare complete symbol streams with a model that scans for zero runs greedily. These are the six-period latency, the correct placement of substitutions for five, six, seven and twelve zeros, the first mark being positive, and the continuity of polarity across substitutions and idle gaps.

// File: rtl/b6zs_pkg.sv
package b6zs_pkg;
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_e;

    // what kind of symbol the current output slot takes
    typedef enum logic [1:0] {
        SLOT_DATA = 2'b00,
        SLOT_ZERO = 2'b01,
        SLOT_V    = 2'b10,
        SLOT_B    = 2'b11
    } slot_e;
endpackage

// File: rtl/b6zs_delay.sv
module b6zs_delay #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic oldest,
    output logic primed,
    output logic run_zero
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [RUN_LEN-1:0] bits;
        logic [CW-1:0]      cnt;
    } dly_s;

    dly_s dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (bit_en) begin
            dly_d.bits = {bit_in, dly_q.bits[RUN_LEN-1:1]};
            if (dly_q.cnt != CW'(RUN_LEN)) begin
                dly_d.cnt = dly_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    assign oldest   = dly_q.bits[0];
    assign primed   = (dly_q.cnt == CW'(RUN_LEN));
    assign run_zero = ~|dly_q.bits;

    // once full, the line stays full until reset
    assert_primed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> primed);
endmodule

// File: rtl/b6zs_subst.sv
module b6zs_subst
    import b6zs_pkg::*;
#(
    parameter int RUN_LEN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire,
    input  logic  run_zero,
    output slot_e slot
);
    localparam int PW = $clog2(RUN_LEN);

    typedef struct packed {
        logic [PW-1:0] pos;
    } sub_s;

    sub_s sub_d, sub_q;

    always_comb begin
        if (sub_q.pos == '0) begin
            slot = run_zero ? SLOT_ZERO : SLOT_DATA;
        end else begin
            case (int'(sub_q.pos) % 3)
                0:       slot = SLOT_ZERO;
                1:       slot = SLOT_V;
                default: slot = SLOT_B;
            endcase
        end
    end

    always_comb begin
        sub_d = sub_q;
        if (fire) begin
            if (sub_q.pos != '0) begin
                sub_d.pos = (sub_q.pos == PW'(RUN_LEN - 1)) ? '0 : sub_q.pos + PW'(1);
            end else if (run_zero) begin
                sub_d.pos = PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else begin
            sub_q <= sub_d;
        end
    end

    assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q.pos < PW'(RUN_LEN));

    // a running substitution is never abandoned mid-way
    assert_pattern_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q.pos != '0) |-> (slot != SLOT_DATA));
endmodule

// File: rtl/b6zs_polarity.sv
module b6zs_polarity
    import b6zs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  slot_e       slot,
    input  logic        data_bit,
    output logic [1:0]  sym,
    output logic        sym_vld
);
    typedef struct packed {
        logic last_pos;
        sym_e sym;
        logic vld;
    } pol_s;

    pol_s pol_d, pol_q;

    always_comb begin
        pol_d     = pol_q;
        pol_d.vld = 1'b0;
        if (fire) begin
            pol_d.vld = 1'b1;
            unique case (slot)
                SLOT_DATA: begin
                    if (data_bit) begin
                        pol_d.last_pos = ~pol_q.last_pos;
                        pol_d.sym      = pol_q.last_pos ? SYM_NEG : SYM_POS;
                    end else begin
                        pol_d.sym = SYM_ZERO;
                    end
                end
                SLOT_ZERO: pol_d.sym = SYM_ZERO;
                SLOT_V:    pol_d.sym = pol_q.last_pos ? SYM_POS : SYM_NEG;
                SLOT_B: begin
                    pol_d.last_pos = ~pol_q.last_pos;
                    pol_d.sym      = pol_q.last_pos ? SYM_NEG : SYM_POS;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '{last_pos: 1'b0, sym: SYM_ZERO, vld: 1'b0};
        end else begin
            pol_q <= pol_d;
        end
    end

    assign sym     = pol_q.sym;
    assign sym_vld = pol_q.vld;

    assert_v_repeats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot == SLOT_V) |=> ($stable(pol_q.last_pos) &&
            sym == (pol_q.last_pos ? 2'b01 : 2'b10)));

    assert_b_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot == SLOT_B) |=> (pol_q.last_pos != $past(pol_q.last_pos)));

    assert_mark_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot == SLOT_DATA && data_bit) |=> (pol_q.last_pos != $past(pol_q.last_pos)));

    assert_zero_is_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot == SLOT_DATA && !data_bit) |=> (sym == 2'b00));
endmodule

// File: rtl/b6zs_encoder.sv
module b6zs_encoder
    import b6zs_pkg::*;
#(
    parameter int RUN_LEN = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic [1:0] sym,
    output logic       sym_vld
);
    logic  oldest;
    logic  primed;
    logic  run_zero;
    logic  fire;
    slot_e slot;

    b6zs_delay #(.RUN_LEN(RUN_LEN)) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .oldest   (oldest),
        .primed   (primed),
        .run_zero (run_zero)
    );

    assign fire = bit_en & primed;

    b6zs_subst #(.RUN_LEN(RUN_LEN)) i_subst (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .run_zero (run_zero),
        .slot     (slot)
    );

    b6zs_polarity i_polarity (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .slot     (slot),
        .data_bit (oldest),
        .sym      (sym),
        .sym_vld  (sym_vld)
    );

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sym != 2'b11);

    assert_vld_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> $past(bit_en));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !sym_vld);
endmodule

// File: tb/test_b6zs_encoder.sv
`timescale 1ns/1ps
module test_b6zs_encoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       bit_in;
    logic [1:0] sym;
    logic       sym_vld;

    always #2.5 clk = ~clk;

    b6zs_encoder i_b6zs_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .sym     (sym),
        .sym_vld (sym_vld)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic       stim  [0:1023];
    logic [1:0] exp_s [0:1023];
    int         exp_t [0:1023];
    int         n_st;

    task automatic check(input bit ok, input int r, input logic [1:0] act,
                         input logic [1:0] expv, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b", r, what, act, expv);
        end
    endtask

    task automatic put(input logic b, input int k);
        for (int j = 0; j < k; j++) begin
            stim[n_st] = b;
            n_st++;
        end
    endtask

    // spec-level model: greedy scan for six-zero runs from the start of the stream
    task automatic model(input int n, input int pt, input int dt);
        logic last_pos;
        bit   seen;
        bit   after_sub;
        int   i;
        bit   allz;
        last_pos  = 1'b0;     // R4: reset polarity is negative
        seen      = 1'b0;
        after_sub = 1'b0;
        i = 0;
        while (i < n) begin
            allz = (i + 5 < n);
            for (int j = 0; j < 6; j++) if (i + j < n && stim[i + j]) allz = 1'b0;
            if (allz) begin
                // R5: 0 V B 0 V B
                exp_s[i]   = 2'b00;
                exp_s[i+1] = last_pos ? 2'b01 : 2'b10;
                last_pos   = ~last_pos;
                exp_s[i+2] = last_pos ? 2'b01 : 2'b10;
                exp_s[i+3] = 2'b00;
                exp_s[i+4] = last_pos ? 2'b01 : 2'b10;
                last_pos   = ~last_pos;
                exp_s[i+5] = last_pos ? 2'b01 : 2'b10;
                for (int j = 0; j < 6; j++) exp_t[i + j] = pt;
                after_sub = 1'b1;
                i += 6;
            end else begin
                if (stim[i]) begin
                    last_pos = ~last_pos;
                    exp_s[i] = last_pos ? 2'b01 : 2'b10;
                    exp_t[i] = !seen ? 4 : (after_sub ? 6 : dt);   // R4, R6, R3
                    seen      = 1'b1;
                    after_sub = 1'b0;
                end else begin
                    exp_s[i] = 2'b00;
                    exp_t[i] = dt;
                end
                i++;
            end
        end
    endtask

    task automatic do_reset;
        rst_n  = 1'b0;
        bit_en = 1'b0;
        bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_vld == 1'b0, 2, {1'b0, sym_vld}, 2'b00, "valid low after reset");
        check(sym == 2'b00, 1, sym, 2'b00, "symbol zero after reset");
    endtask

    task automatic run(input int pt, input int dt, input int gap_seed);
        model(n_st, pt, dt);
        do_reset();
        for (int i = 0; i < n_st; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = stim[i];
            @(negedge clk);
            bit_en = 1'b0;
            if (i >= 6) begin
                check(sym_vld == 1'b1, 2, {1'b0, sym_vld}, 2'b01, "valid pulse after enable");
                check(sym == exp_s[i-6], exp_t[i-6], sym, exp_s[i-6], "symbol");
                check(sym != 2'b11, 1, sym, 2'b00, "illegal code");
            end else begin
                check(sym_vld == 1'b0, 2, {1'b0, sym_vld}, 2'b00, "no output while filling");
            end
            if (((i + gap_seed) % 5) == 0) begin
                // R8: idle cycle, nothing happens
                @(negedge clk);
                check(sym_vld == 1'b0, 8, {1'b0, sym_vld}, 2'b00, "idle cycle quiet");
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R3 / R4: plain alternation
        n_st = 0;
        put(1, 2); put(0, 1); put(1, 2); put(0, 2); put(1, 1); put(1, 6);
        run(5, 3, 0);
        // R5 / R6: one substitution between marks
        n_st = 0;
        put(1, 1); put(0, 6); put(1, 2); put(0, 6); put(1, 1); put(1, 6);
        run(5, 3, 1);
        // R7: twelve, seven and five zeros
        n_st = 0;
        put(1, 1); put(0, 12); put(1, 1); put(0, 7); put(1, 1); put(0, 5); put(1, 1);
        put(0, 13); put(1, 6);
        run(7, 7, 2);
        // exhaustive over ten-bit words, flushed with ones
        for (int w = 0; w < 1024; w++) begin
            n_st = 0;
            for (int b = 0; b < 10; b++) put(w[b], 1);
            put(1, 6);
            run(5, 3, w % 5);
        end
        // long zero-heavy stream
        lfsr = 16'hACE1;
        n_st = 0;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            put(lfsr[0] & lfsr[5], 1);
        end
        put(1, 6);
        run(5, 3, 3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule